// File: doc/BRIEF.md
# Gated 13/16-bit Counter/Timer

A single counter/timer channel of the kind found beside a small 8-bit processor core. The count is held in a low byte and a high byte. Two widths are available. In the 16-bit mode both bytes count as one value. In the 13-bit mode only the five least significant bits of the low byte take part, sitting under the full high byte. The count wraps from all ones to zero. On that wrap it raises an overflow flag, which stays raised until software clears it.

Each count step comes from one of three tick sources, chosen by two select bits:
- every system clock,
- a one-cycle prescaler enable pulse,
- a falling edge on an external count pin, which is synchronised first.

Counting runs only while the run bit is set. An optional gate can also hold it off unless an external line sits at its programmed active level, which makes the block usable for pulse-width measurement. Software loads the bytes directly, and its writes override counting. All control and status pins are plain level signals; there is no streaming data path, so no valid/ready handshake applies.

Top module: `gated_ctr_timer`

## Requirements
- R1: After reset both count bytes read 0x00 and the overflow flag is 0.
- R2: With the external-source select at 0 and the clock-source select at 1, an enabled counter advances by one on every system clock.
- R3: With both select bits at 0, an enabled counter advances by one only in cycles where the prescaler pulse input is 1.
- R4: With the external-source select at 1, the count advances once for each high-to-low transition of the count pin; rising edges and steady levels add nothing.
- R5: While the run bit is 0 and no byte is written, the count does not change.
- R6: With the gate enable at 1, counting happens only while the gate line equals the polarity bit (polarity 1 means active high, 0 means active low); with the gate enable at 0, the gate line has no effect.
- R7: In 13-bit mode (mode input 0), a carry out of low bits [4:0] increments the high byte, and low bits [7:5] keep their written value.
- R8: In 13-bit mode, a step from high 0xFF, low bits [4:0] = 0x1F gives high 0x00 and low bits [4:0] = 0x00, and sets the overflow flag.
- R9: In 16-bit mode (mode input 1), a step from 0xFFFF gives 0x0000 and sets the overflow flag; a carry from the low byte increments the high byte.
- R10: The overflow flag stays 1 until the clear input is pulsed; a new overflow in the same cycle as a clear leaves it at 1.
- R11: A byte write in a cycle takes priority over the count step of that cycle: the written byte takes the new value and no step is applied.
- R12: Setting the run bit does not clear the count; counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 0: 13-bit count, 1: 16-bit count |
| src_ext | input | 1 | 1: count falling edges of the count pin |
| src_sysclk | input | 1 | When src_ext is 0: 1 = system clock, 0 = prescaler pulse |
| run | input | 1 | Run enable |
| gate_en | input | 1 | Gate counting on the gate line |
| gate_pol | input | 1 | Active level of the gate line |
| gate_line | input | 1 | External gate line (asynchronous level) |
| presc_pulse | input | 1 | One-cycle prescaler enable |
| count_pin | input | 1 | External count pin (asynchronous) |
| lo_wr | input | 1 | Write wr_data into the low byte |
| hi_wr | input | 1 | Write wr_data into the high byte |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | Clear the overflow flag |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A broken tick select or gate shows on the byte outputs within one clock, as a count that drifts from the expected tick total. A fault in the pin synchroniser shows within three clocks of a pin edge, as a missing or doubled step. A wrong carry path into the high byte only shows at the low-field boundary, and a wrong wrap point only at the terminal count. For that reason the tests preload values one or two steps short of those boundaries and read both bytes and the flag right after each step.

// File: rtl/gated_ctr_pkg.sv
package gated_ctr_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SHORT_LO = 5;

  typedef enum logic {
    WIDTH_13 = 1'b0,
    WIDTH_16 = 1'b1
  } ctr_width_e;

  typedef enum logic [1:0] {
    SRC_PRESC  = 2'd0,
    SRC_SYSCLK = 2'd1,
    SRC_PIN    = 2'd2
  } tick_src_e;
endpackage

// File: rtl/ctr_pin_edge.sv
module ctr_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign pin_fall = prev_q & ~sync_q[STAGES-1];

  // R4: one edge yields a single-cycle tick, never two in a row
  a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall);
endmodule

// File: rtl/ctr_tick_ctrl.sv
module ctr_tick_ctrl
  import gated_ctr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic src_sysclk,
  input  logic run,
  input  logic gate_en,
  input  logic gate_pol,
  input  logic gate_line,
  input  logic presc_pulse,
  input  logic pin_fall,
  output logic step
);
  tick_src_e src;
  logic      raw_tick;
  logic      gate_open;

  always_comb begin
    if (src_ext)         src = SRC_PIN;
    else if (src_sysclk) src = SRC_SYSCLK;
    else                 src = SRC_PRESC;
    unique case (src)
      SRC_PIN:    raw_tick = pin_fall;
      SRC_SYSCLK: raw_tick = 1'b1;
      default:    raw_tick = presc_pulse;
    endcase
    gate_open = ~gate_en | (gate_line ^ ~gate_pol);
    step      = run & gate_open & raw_tick;
  end

  // R6: a closed gate blocks every tick
  a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (gate_line != gate_pol)) |-> !step);
  // R3: prescaled source without a pulse gives no step
  a_r3_presc_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ext && !src_sysclk && !presc_pulse) |-> !step);
endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core
  import gated_ctr_pkg::*;
#(
  parameter int unsigned LO_W = BYTE_W,
  parameter int unsigned HI_W = BYTE_W,
  parameter int unsigned SL_W = SHORT_LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctr_width_e      width,
  input  logic            step,
  input  logic            lo_wr,
  input  logic            hi_wr,
  input  logic [LO_W-1:0] lo_data,
  input  logic [HI_W-1:0] hi_data,
  input  logic            ovf_clr,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q,
  output logic            ovf_q
);
  localparam int unsigned WIDE_W  = LO_W + HI_W;
  localparam int unsigned SHORT_W = SL_W + HI_W;

  logic [WIDE_W-1:0]  wide_cur, wide_nxt;
  logic [SHORT_W-1:0] short_cur, short_nxt;
  logic               at_top;
  logic               any_wr;

  always_comb begin
    wide_cur  = {hi_q, lo_q};
    short_cur = {hi_q, lo_q[SL_W-1:0]};
    wide_nxt  = wide_cur + WIDE_W'(1);
    short_nxt = short_cur + SHORT_W'(1);
    at_top    = (width == WIDTH_16) ? (&wide_cur) : (&short_cur);
    any_wr    = lo_wr | hi_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (lo_wr) lo_q <= lo_data;
      if (hi_wr) hi_q <= hi_data;
    end else if (step) begin
      if (width == WIDTH_16) begin
        {hi_q, lo_q} <= wide_nxt;
      end else begin
        hi_q             <= short_nxt[SHORT_W-1:SL_W];
        lo_q[SL_W-1:0]   <= short_nxt[SL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ovf_q <= 1'b0;
    else if (!any_wr && step && at_top) ovf_q <= 1'b1;
    else if (ovf_clr)                   ovf_q <= 1'b0;
  end

  // R11: a write lands unchanged even while counting
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (lo_q == $past(lo_data)));
  // R10: flag holds without a clear
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R8/R9: terminal step wraps to zero and raises the flag
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr && at_top) |=> (ovf_q && hi_q == '0));
  // R7: upper low bits never move in 13-bit mode without a write
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (width == WIDTH_13 && !lo_wr) |=> $stable(lo_q[LO_W-1:SL_W]));
endmodule

// File: rtl/gated_ctr_timer.sv
module gated_ctr_timer
  import gated_ctr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              src_ext,
  input  logic              src_sysclk,
  input  logic              run,
  input  logic              gate_en,
  input  logic              gate_pol,
  input  logic              gate_line,
  input  logic              presc_pulse,
  input  logic              count_pin,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_flag
);
  logic       pin_fall;
  logic       step;
  ctr_width_e width;

  assign width = ctr_width_e'(mode_wide);

  ctr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (count_pin),
    .pin_fall  (pin_fall)
  );

  ctr_tick_ctrl u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_ext     (src_ext),
    .src_sysclk  (src_sysclk),
    .run         (run),
    .gate_en     (gate_en),
    .gate_pol    (gate_pol),
    .gate_line   (gate_line),
    .presc_pulse (presc_pulse),
    .pin_fall    (pin_fall),
    .step        (step)
  );

  ctr_count_core #(.LO_W(BYTE_W), .HI_W(BYTE_W), .SL_W(SHORT_LO)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .width   (width),
    .step    (step),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .lo_data (wr_data),
    .hi_data (wr_data),
    .ovf_clr (ovf_clr),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ovf_q   (ovf_flag)
  );

  // R5: a stopped counter with no writes holds its value
  a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !lo_wr && !hi_wr) |=> $stable({hi_q, lo_q}));
endmodule

// File: tb/gated_ctr_timer_bench.sv
module gated_ctr_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wide = 1'b1, src_ext = 1'b0, src_sysclk = 1'b1, run = 1'b0;
  logic       gate_en = 1'b0, gate_pol = 1'b1, gate_line = 1'b0;
  logic       presc_pulse = 1'b0, count_pin = 1'b1;
  logic       lo_wr = 1'b0, hi_wr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] lo_q, hi_q;
  logic       ovf_flag;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gated_ctr_timer u_gated_ctr_timer (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .src_ext(src_ext),
    .src_sysclk(src_sysclk), .run(run), .gate_en(gate_en), .gate_pol(gate_pol),
    .gate_line(gate_line), .presc_pulse(presc_pulse), .count_pin(count_pin),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .lo_q(lo_q), .hi_q(hi_q), .ovf_flag(ovf_flag)
  );

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(logic [7:0] lo, logic [7:0] hi);
    @(negedge clk); lo_wr = 1'b1; wr_data = lo;
    @(negedge clk); lo_wr = 1'b0; hi_wr = 1'b1; wr_data = hi;
    @(negedge clk); hi_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", {ovf_flag, hi_q, lo_q}, 17'h0);
  endtask

  task automatic t_sysclk_hold();
    mode_wide = 1'b1; src_ext = 1'b0; src_sysclk = 1'b1;
    load(8'h10, 8'h00);
    run = 1'b1; cyc(5); run = 1'b0;
    chk("R2", {ovf_flag, hi_q, lo_q}, {1'b0, 16'h0015});
    cyc(4);
    chk("R5", {ovf_flag, hi_q, lo_q}, {1'b0, 16'h0015});
    run = 1'b1; cyc(2); run = 1'b0;
    chk("R12", {ovf_flag, hi_q, lo_q}, {1'b0, 16'h0017});
  endtask

  task automatic t_presc();
    src_sysclk = 1'b0; load(8'h00, 8'h00);
    run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      presc_pulse = (i % 2 == 0);
      @(negedge clk);
    end
    presc_pulse = 1'b0; run = 1'b0;
    chk("R3", {hi_q, lo_q}, 17'h0003);
  endtask

  task automatic t_pin();
    src_ext = 1'b1; load(8'h00, 8'h00);
    run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      count_pin = 1'b0; cyc(4);
      count_pin = 1'b1; cyc(4);
    end
    chk("R4", {hi_q, lo_q}, 17'h0004);
    cyc(6);
    chk("R4", {hi_q, lo_q}, 17'h0004);
    run = 1'b0; src_ext = 1'b0;
  endtask

  task automatic t_gate();
    src_sysclk = 1'b1; load(8'h00, 8'h00);
    gate_en = 1'b1; gate_pol = 1'b1; gate_line = 1'b0;
    run = 1'b1; cyc(3);
    chk("R6", {hi_q, lo_q}, 17'h0000);
    gate_line = 1'b1; cyc(3);
    chk("R6", {hi_q, lo_q}, 17'h0003);
    gate_pol = 1'b0; gate_line = 1'b0; cyc(2);
    chk("R6", {hi_q, lo_q}, 17'h0005);
    gate_line = 1'b1; cyc(2);
    chk("R6", {hi_q, lo_q}, 17'h0005);
    gate_en = 1'b0; cyc(2); run = 1'b0;
    chk("R6", {hi_q, lo_q}, 17'h0007);
  endtask

  task automatic t_mode13();
    mode_wide = 1'b0; load(8'hFF, 8'h02);
    run = 1'b1; cyc(1); run = 1'b0;
    chk("R7", {hi_q, lo_q}, 17'h03E0);
    load(8'h5E, 8'hFF);
    run = 1'b1; cyc(1); run = 1'b0;
    chk("R8", {ovf_flag, hi_q, lo_q}, {1'b0, 16'hFF5F});
    run = 1'b1; cyc(1); run = 1'b0;
    chk("R8", {ovf_flag, hi_q, lo_q}, {1'b1, 16'h0040});
    cyc(3);
    chk("R10", {16'h0, ovf_flag}, 17'h1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R10", {16'h0, ovf_flag}, 17'h0);
  endtask

  task automatic t_mode16();
    mode_wide = 1'b1; load(8'hFF, 8'h00);
    run = 1'b1; cyc(1); run = 1'b0;
    chk("R9", {ovf_flag, hi_q, lo_q}, {1'b0, 16'h0100});
    load(8'hFE, 8'hFF);
    run = 1'b1; cyc(2); run = 1'b0;
    chk("R9", {ovf_flag, hi_q, lo_q}, {1'b1, 16'h0000});
    load(8'hFF, 8'hFF);
    run = 1'b1; ovf_clr = 1'b1; cyc(1); run = 1'b0; ovf_clr = 1'b0;
    chk("R10", {ovf_flag, hi_q, lo_q}, {1'b1, 16'h0000});
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
  endtask

  task automatic t_write_prio();
    load(8'h00, 8'h00);
    run = 1'b1; cyc(2);
    lo_wr = 1'b1; wr_data = 8'h33; cyc(1); lo_wr = 1'b0;
    chk("R11", {hi_q, lo_q}, 17'h0033);
    cyc(1); run = 1'b0;
    chk("R11", {hi_q, lo_q}, 17'h0034);
    load(8'hFF, 8'hFF);
    run = 1'b1; hi_wr = 1'b1; wr_data = 8'hFF; cyc(1); hi_wr = 1'b0; run = 1'b0;
    chk("R11", {ovf_flag, hi_q, lo_q}, {1'b0, 16'hFFFF});
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_sysclk_hold();
    t_presc();
    t_pin();
    t_gate();
    t_mode13();
    t_mode16();
    t_write_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule